// File: doc/BRIEF.md
# Two-Level Tag Hierarchy Model

This block keeps the tag state of a mid-level cache and a last-level cache that sit behind a first-level cache and take its stream of misses. Each incoming request carries an address and a flag that tells a genuine miss from an upgrade request. For a genuine miss the block looks up the mid-level tags first, then the last-level tags. It fills, drops and moves lines as the selected inclusion policy requires, and it keeps least-recently-used order for every set. No data is stored: the block exists to count misses at both levels for a given request stream.

A two-bit policy input selects how the levels relate. Inclusive mode removes a line from the mid level when the last level evicts it. Non-inclusive-non-exclusive mode fills both levels but never back-invalidates. Exclusive mode fills only the mid level and uses the last level as a victim store for lines it evicts. Requests follow a valid/ready handshake and are served one at a time. Each one ends with a single-cycle response that carries two miss flags. Two running counters total the misses at each level. Set count, associativity, line size and address width are all parameters, so a small geometry can be used in simulation while a full-size one is used in the product.

Top module: `cache_tag_hier`

## Requirements
- R1: After a synchronous reset every line is invalid, both miss counters read 0, `req_ready_o` is high and `resp_valid_o` is low, so the first genuine request to any line misses at both levels.
- R2: A request with `req_real_i` = 0 (upgrade request) is answered one cycle after acceptance with both miss flags low. It changes no tag, no LRU state and no counter, so a later genuine request to that same line still misses at both levels.
- R3: The low log2(LINE_BYTES) address bits (6 by default) select the byte within a line and do not affect lookup. The next log2(sets) bits pick the set, and the rest form the tag.
- R4: A mid-level hit answers with both flags low, updates only mid-level LRU state and leaves the last level untouched. The last-level miss flag is never set without the mid-level miss flag.
- R5: `req_ready_o` drops in the cycle after a genuine request is accepted and rises again in the cycle the response appears. Every accepted request gets exactly one `resp_valid_o` pulse, which lasts one cycle.
- R6: A fill into a set uses the lowest-numbered invalid way if there is one, and otherwise the least recently used way. A filled or touched line becomes most recently used.
- R7: With `policy_i` = 0 (inclusive), a miss at both levels fills the last level and then the mid level. A valid line evicted from the last level is invalidated in the mid level, and that freed way is filled first.
- R8: With `policy_i` = 1 (non-inclusive-non-exclusive, also used for code 3), a miss at both levels fills both levels, and a last-level eviction leaves the mid level unchanged. In both this mode and inclusive mode, a last-level hit fills the mid level and makes the line most recent in the last level.
- R9: With `policy_i` = 2 (exclusive), a miss at both levels fills only the mid level. A valid line evicted from the mid level is allocated in the last level, and a last-level hit moves the line to the mid level and invalidates it in the last level.
- R10: `l2_miss_cnt_o` grows by exactly one for each mid-level miss and `l3_miss_cnt_o` by exactly one for each last-level miss. Neither changes in any other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| policy_i | input | 2 | Inclusion policy: 0 inclusive, 1 or 3 non-inclusive-non-exclusive, 2 exclusive; taken only while idle |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | High while idle and able to accept a request |
| req_addr_i | input | ADDR_W | Byte address of the missing line |
| req_real_i | input | 1 | 1 = genuine miss, 0 = upgrade request treated as a hit |
| resp_valid_o | output | 1 | One-cycle pulse that ends each request |
| resp_l2_miss_o | output | 1 | Request missed the mid level |
| resp_l3_miss_o | output | 1 | Request missed the last level |
| l2_miss_cnt_o | output | CNT_W | Running count of mid-level misses |
| l3_miss_cnt_o | output | CNT_W | Running count of last-level misses |

## Verification
A corrupted tag, valid bit or age in this block does not show on any port when it happens. It shows only when a later request reaches the same set: a flag is wrong in that request's response and a counter drifts by one from that point on. The stimulus therefore sends long chains of requests to a single set, so that each eviction choice, back-invalidation and victim move is tested by the very next request that depends on it. Each chain is run under all three policies, so a change in any one policy's handling gives a different flag within a few requests.

// File: rtl/tch_pkg.sv
package tch_pkg;

    typedef enum logic [1:0] {
        POL_INCL = 2'd0,
        POL_NINE = 2'd1,
        POL_EXCL = 2'd2
    } pol_e;

    typedef enum logic [1:0] {
        TOP_NONE  = 2'd0,
        TOP_TOUCH = 2'd1,
        TOP_FILL  = 2'd2,
        TOP_DROP  = 2'd3
    } tag_op_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_L2_LOOK  = 3'd1,
        ST_L3_LOOK  = 3'd2,
        ST_BACKINV  = 3'd3,
        ST_L2_FILL  = 3'd4,
        ST_L3_ALLOC = 3'd5
    } ctl_state_e;

endpackage

// File: rtl/tch_victim_sel.sv
module tch_victim_sel #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0][WAY_W-1:0]  age_i,
    output logic [WAY_W-1:0]            way_o,
    output logic                        taken_o
);

    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic             free_found;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] lru_way;

    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
    end

    always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_i[w] == OLDEST) begin
                lru_way = WAY_W'(w);
            end
        end
    end

    assign way_o   = free_found ? free_way : lru_way;
    assign taken_o = !free_found;

endmodule

// File: rtl/tch_tag_store.sv
module tch_tag_store
    import tch_pkg::*;
#(
    parameter int SETS   = 2,
    parameter int WAYS   = 4,
    parameter int LINE_W = 26
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [LINE_W-1:0]          line_i,
    input  tag_op_e                    op_i,
    input  logic [$clog2(WAYS)-1:0]    op_way_i,
    output logic                       hit_o,
    output logic [$clog2(WAYS)-1:0]    hit_way_o,
    output logic [$clog2(WAYS)-1:0]    vic_way_o,
    output logic                       vic_valid_o,
    output logic [LINE_W-1:0]          vic_line_o
);

    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = LINE_W - SET_W;
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0]             valid_q [SETS];
    logic [WAYS-1:0]             valid_d [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_d   [SETS];
    logic [WAYS-1:0][WAY_W-1:0]  age_q   [SETS];
    logic [WAYS-1:0][WAY_W-1:0]  age_d   [SETS];

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] tag_in;
    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] pivot_age;

    assign set_idx = line_i[SET_W-1:0];
    assign tag_in  = line_i[LINE_W-1:SET_W];

    // lookup in the addressed set
    always_comb begin
        hit_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = valid_q[set_idx][w] && (tag_q[set_idx][w] == tag_in);
            if (hit_vec[w]) begin
                hit_way_o = WAY_W'(w);
            end
        end
    end
    assign hit_o = |hit_vec;

    tch_victim_sel #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) u_vsel (
        .valid_i (valid_q[set_idx]),
        .age_i   (age_q[set_idx]),
        .way_o   (vic_way_o),
        .taken_o (vic_valid_o)
    );

    assign vic_line_o = {tag_q[set_idx][vic_way_o], set_idx};
    assign pivot_age  = age_q[set_idx][op_way_i];

    // next state: ages stay a permutation of 0..WAYS-1 in every set
    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        age_d   = age_q;
        if (op_i == TOP_TOUCH || op_i == TOP_FILL) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == op_way_i) begin
                    age_d[set_idx][w] = '0;
                end else if (age_q[set_idx][w] < pivot_age) begin
                    age_d[set_idx][w] = age_q[set_idx][w] + 1'b1;
                end
            end
        end
        if (op_i == TOP_FILL) begin
            valid_d[set_idx][op_way_i] = 1'b1;
            tag_d[set_idx][op_way_i]   = tag_in;
        end
        if (op_i == TOP_DROP) begin
            valid_d[set_idx][op_way_i] = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                tag_q[s]   <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            valid_q <= valid_d;
            tag_q   <= tag_d;
            age_q   <= age_d;
        end
    end

    AST_FILL_ONLY_ON_MISS: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == TOP_FILL) |-> !hit_o); // R6
    AST_SINGLE_COPY: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(hit_vec)); // R6
    AST_TOUCH_ON_HIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == TOP_TOUCH) |-> (hit_o && hit_way_o == op_way_i)); // R4

endmodule

// File: rtl/cache_tag_hier.sv
module cache_tag_hier
    import tch_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int L2_SETS    = 2,
    parameter int L2_WAYS    = 2,
    parameter int L3_SETS    = 2,
    parameter int L3_WAYS    = 4,
    parameter int CNT_W      = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        policy_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_real_i,
    output logic              resp_valid_o,
    output logic              resp_l2_miss_o,
    output logic              resp_l3_miss_o,
    output logic [CNT_W-1:0]  l2_miss_cnt_o,
    output logic [CNT_W-1:0]  l3_miss_cnt_o
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int L2_WW  = $clog2(L2_WAYS);
    localparam int L3_WW  = $clog2(L3_WAYS);

    typedef struct packed {
        ctl_state_e        state;
        pol_e              policy;
        logic [LINE_W-1:0] line;
        logic [LINE_W-1:0] vic_line;
        logic              l3_missed;
        logic              resp_valid;
        logic              resp_l2m;
        logic              resp_l3m;
        logic [CNT_W-1:0]  l2_cnt;
        logic [CNT_W-1:0]  l3_cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LINE_W-1:0] l2_line, l3_line;
    tag_op_e           l2_op, l3_op;
    logic [L2_WW-1:0]  l2_op_way, l2_hit_way, l2_vic_way;
    logic [L3_WW-1:0]  l3_op_way, l3_hit_way, l3_vic_way;
    logic              l2_hit, l2_vic_valid, l3_hit, l3_vic_valid;
    logic [LINE_W-1:0] l2_vic_line, l3_vic_line;
    logic              unused_offset;

    assign unused_offset = ^req_addr_i[OFF_W-1:0];

    tch_tag_store #(
        .SETS   (L2_SETS),
        .WAYS   (L2_WAYS),
        .LINE_W (LINE_W)
    ) u_l2 (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .line_i      (l2_line),
        .op_i        (l2_op),
        .op_way_i    (l2_op_way),
        .hit_o       (l2_hit),
        .hit_way_o   (l2_hit_way),
        .vic_way_o   (l2_vic_way),
        .vic_valid_o (l2_vic_valid),
        .vic_line_o  (l2_vic_line)
    );

    tch_tag_store #(
        .SETS   (L3_SETS),
        .WAYS   (L3_WAYS),
        .LINE_W (LINE_W)
    ) u_l3 (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .line_i      (l3_line),
        .op_i        (l3_op),
        .op_way_i    (l3_op_way),
        .hit_o       (l3_hit),
        .hit_way_o   (l3_hit_way),
        .vic_way_o   (l3_vic_way),
        .vic_valid_o (l3_vic_valid),
        .vic_line_o  (l3_vic_line)
    );

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.resp_valid = 1'b0;
        l2_line          = ctl_q.line;
        l3_line          = ctl_q.line;
        l2_op            = TOP_NONE;
        l3_op            = TOP_NONE;
        l2_op_way        = '0;
        l3_op_way        = '0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                unique case (policy_i)
                    2'd0:    ctl_d.policy = POL_INCL;
                    2'd2:    ctl_d.policy = POL_EXCL;
                    default: ctl_d.policy = POL_NINE;
                endcase
                if (req_valid_i) begin
                    if (!req_real_i) begin
                        ctl_d.resp_valid = 1'b1;
                        ctl_d.resp_l2m   = 1'b0;
                        ctl_d.resp_l3m   = 1'b0;
                    end else begin
                        ctl_d.line  = req_addr_i[ADDR_W-1:OFF_W];
                        ctl_d.state = ST_L2_LOOK;
                    end
                end
            end

            ST_L2_LOOK: begin
                if (l2_hit) begin
                    l2_op            = TOP_TOUCH;
                    l2_op_way        = l2_hit_way;
                    ctl_d.resp_valid = 1'b1;
                    ctl_d.resp_l2m   = 1'b0;
                    ctl_d.resp_l3m   = 1'b0;
                    ctl_d.state      = ST_IDLE;
                end else begin
                    ctl_d.l2_cnt = ctl_q.l2_cnt + 1'b1;
                    ctl_d.state  = ST_L3_LOOK;
                end
            end

            ST_L3_LOOK: begin
                ctl_d.state = ST_L2_FILL;
                if (l3_hit) begin
                    l3_op           = (ctl_q.policy == POL_EXCL) ? TOP_DROP : TOP_TOUCH;
                    l3_op_way       = l3_hit_way;
                    ctl_d.l3_missed = 1'b0;
                end else begin
                    ctl_d.l3_cnt    = ctl_q.l3_cnt + 1'b1;
                    ctl_d.l3_missed = 1'b1;
                    if (ctl_q.policy != POL_EXCL) begin
                        l3_op          = TOP_FILL;
                        l3_op_way      = l3_vic_way;
                        ctl_d.vic_line = l3_vic_line;
                        if (ctl_q.policy == POL_INCL && l3_vic_valid) begin
                            ctl_d.state = ST_BACKINV;
                        end
                    end
                end
            end

            ST_BACKINV: begin
                l2_line = ctl_q.vic_line;
                if (l2_hit) begin
                    l2_op     = TOP_DROP;
                    l2_op_way = l2_hit_way;
                end
                ctl_d.state = ST_L2_FILL;
            end

            ST_L2_FILL: begin
                l2_op     = TOP_FILL;
                l2_op_way = l2_vic_way;
                if (ctl_q.policy == POL_EXCL && l2_vic_valid) begin
                    ctl_d.vic_line = l2_vic_line;
                    ctl_d.state    = ST_L3_ALLOC;
                end else begin
                    ctl_d.resp_valid = 1'b1;
                    ctl_d.resp_l2m   = 1'b1;
                    ctl_d.resp_l3m   = ctl_q.l3_missed;
                    ctl_d.state      = ST_IDLE;
                end
            end

            ST_L3_ALLOC: begin
                l3_line = ctl_q.vic_line;
                if (l3_hit) begin
                    l3_op     = TOP_TOUCH;
                    l3_op_way = l3_hit_way;
                end else begin
                    l3_op     = TOP_FILL;
                    l3_op_way = l3_vic_way;
                end
                ctl_d.resp_valid = 1'b1;
                ctl_d.resp_l2m   = 1'b1;
                ctl_d.resp_l3m   = ctl_q.l3_missed;
                ctl_d.state      = ST_IDLE;
            end

            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= '{state: ST_IDLE, policy: POL_INCL, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready_o    = (ctl_q.state == ST_IDLE);
    assign resp_valid_o   = ctl_q.resp_valid;
    assign resp_l2_miss_o = ctl_q.resp_l2m;
    assign resp_l3_miss_o = ctl_q.resp_l3m;
    assign l2_miss_cnt_o  = ctl_q.l2_cnt;
    assign l3_miss_cnt_o  = ctl_q.l3_cnt;

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && req_ready_o && req_real_i) |=> !req_ready_o); // R5
    AST_UPGRADE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && req_ready_o && !req_real_i) |=>
        (resp_valid_o && !resp_l2_miss_o && !resp_l3_miss_o
         && $stable(l2_miss_cnt_o) && $stable(l3_miss_cnt_o))); // R2
    AST_L3_MISS_IMPLIES_L2: assert property (@(posedge clk_i) disable iff (rst_i)
        (resp_valid_o && resp_l3_miss_o) |-> resp_l2_miss_o); // R4
    AST_L2_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (l2_miss_cnt_o != $past(l2_miss_cnt_o)) |->
        (l2_miss_cnt_o == $past(l2_miss_cnt_o) + 1'b1)); // R10
    AST_L3_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (l3_miss_cnt_o != $past(l3_miss_cnt_o)) |->
        (l3_miss_cnt_o == $past(l3_miss_cnt_o) + 1'b1)); // R10
    AST_RESP_RELEASES_READY: assert property (@(posedge clk_i) disable iff (rst_i)
        resp_valid_o |-> req_ready_o); // R5

endmodule

// File: tb/cache_tag_hier_bench.sv
`timescale 1ns/1ps
module cache_tag_hier_bench;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 32;
    localparam int NVEC   = 37;

    // {restart, policy[1:0], real, addr[15:0], l2m, l3m, l2cnt[7:0], l3cnt[7:0]}
    localparam logic [37:0] VEC [NVEC] = '{
        // inclusive: R1 R3 R6 R7 R10
        {1'b1, 2'd0, 1'b1, 16'h0080, 1'b1, 1'b1, 8'd1, 8'd1},
        {1'b0, 2'd0, 1'b1, 16'h00BF, 1'b0, 1'b0, 8'd1, 8'd1},
        {1'b0, 2'd0, 1'b1, 16'h0100, 1'b1, 1'b1, 8'd2, 8'd2},
        {1'b0, 2'd0, 1'b1, 16'h0080, 1'b0, 1'b0, 8'd2, 8'd2},
        {1'b0, 2'd0, 1'b1, 16'h0180, 1'b1, 1'b1, 8'd3, 8'd3},
        {1'b0, 2'd0, 1'b1, 16'h0080, 1'b0, 1'b0, 8'd3, 8'd3},
        {1'b0, 2'd0, 1'b1, 16'h0200, 1'b1, 1'b1, 8'd4, 8'd4},
        {1'b0, 2'd0, 1'b1, 16'h0080, 1'b0, 1'b0, 8'd4, 8'd4},
        {1'b0, 2'd0, 1'b1, 16'h0280, 1'b1, 1'b1, 8'd5, 8'd5},
        {1'b0, 2'd0, 1'b1, 16'h0200, 1'b0, 1'b0, 8'd5, 8'd5},
        {1'b0, 2'd0, 1'b1, 16'h0080, 1'b1, 1'b1, 8'd6, 8'd6},
        {1'b0, 2'd0, 1'b1, 16'h0280, 1'b1, 1'b0, 8'd7, 8'd6},
        {1'b0, 2'd0, 1'b1, 16'h0040, 1'b1, 1'b1, 8'd8, 8'd7},
        {1'b0, 2'd0, 1'b0, 16'h00C0, 1'b0, 1'b0, 8'd8, 8'd7},
        {1'b0, 2'd0, 1'b1, 16'h00C0, 1'b1, 1'b1, 8'd9, 8'd8},
        // non-inclusive-non-exclusive: R8
        {1'b1, 2'd1, 1'b1, 16'h0080, 1'b1, 1'b1, 8'd1, 8'd1},
        {1'b0, 2'd1, 1'b1, 16'h0100, 1'b1, 1'b1, 8'd2, 8'd2},
        {1'b0, 2'd1, 1'b1, 16'h0080, 1'b0, 1'b0, 8'd2, 8'd2},
        {1'b0, 2'd1, 1'b1, 16'h0180, 1'b1, 1'b1, 8'd3, 8'd3},
        {1'b0, 2'd1, 1'b1, 16'h0080, 1'b0, 1'b0, 8'd3, 8'd3},
        {1'b0, 2'd1, 1'b1, 16'h0200, 1'b1, 1'b1, 8'd4, 8'd4},
        {1'b0, 2'd1, 1'b1, 16'h0080, 1'b0, 1'b0, 8'd4, 8'd4},
        {1'b0, 2'd1, 1'b1, 16'h0280, 1'b1, 1'b1, 8'd5, 8'd5},
        {1'b0, 2'd1, 1'b1, 16'h0080, 1'b0, 1'b0, 8'd5, 8'd5},
        {1'b0, 2'd1, 1'b1, 16'h0200, 1'b1, 1'b0, 8'd6, 8'd5},
        {1'b0, 2'd1, 1'b1, 16'h0200, 1'b0, 1'b0, 8'd6, 8'd5},
        // exclusive: R9
        {1'b1, 2'd2, 1'b1, 16'h0080, 1'b1, 1'b1, 8'd1, 8'd1},
        {1'b0, 2'd2, 1'b1, 16'h0100, 1'b1, 1'b1, 8'd2, 8'd2},
        {1'b0, 2'd2, 1'b1, 16'h0180, 1'b1, 1'b1, 8'd3, 8'd3},
        {1'b0, 2'd2, 1'b1, 16'h0080, 1'b1, 1'b0, 8'd4, 8'd3},
        {1'b0, 2'd2, 1'b1, 16'h0080, 1'b0, 1'b0, 8'd4, 8'd3},
        {1'b0, 2'd2, 1'b1, 16'h0100, 1'b1, 1'b0, 8'd5, 8'd3},
        {1'b0, 2'd2, 1'b1, 16'h0200, 1'b1, 1'b1, 8'd6, 8'd4},
        {1'b0, 2'd2, 1'b1, 16'h0280, 1'b1, 1'b1, 8'd7, 8'd5},
        {1'b0, 2'd2, 1'b1, 16'h0300, 1'b1, 1'b1, 8'd8, 8'd6},
        {1'b0, 2'd2, 1'b1, 16'h0380, 1'b1, 1'b1, 8'd9, 8'd7},
        {1'b0, 2'd2, 1'b1, 16'h0180, 1'b1, 1'b1, 8'd10, 8'd8}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        policy = 2'd0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_real = 1'b0;
    logic              resp_valid, resp_l2m, resp_l3m;
    logic [CNT_W-1:0]  l2_cnt, l3_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cache_tag_hier u_cache_tag_hier (
        .clk_i          (clk),
        .rst_i          (rst),
        .policy_i       (policy),
        .req_valid_i    (req_valid),
        .req_ready_o    (req_ready),
        .req_addr_i     (req_addr),
        .req_real_i     (req_real),
        .resp_valid_o   (resp_valid),
        .resp_l2_miss_o (resp_l2m),
        .resp_l3_miss_o (resp_l3m),
        .l2_miss_cnt_o  (l2_cnt),
        .l3_miss_cnt_o  (l3_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic [1:0] pol, input logic kind, input logic [15:0] addr,
                        output logic l2m, output logic l3m, output bit got);
        @(negedge clk);
        policy    = pol;
        req_valid = 1'b1;
        req_real  = kind;
        req_addr  = ADDR_W'(addr);
        @(negedge clk);
        req_valid = 1'b0;
        got = 1'b0;
        l2m = 1'b0;
        l3m = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (resp_valid) begin
                got = 1'b1;
                l2m = resp_l2m;
                l3m = resp_l3m;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R5 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic l2m, l3m;
        bit   got;

        // R1: reset state
        do_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R1 no response after reset", int'(resp_valid), 0);
        check(l2_cnt == 0 && l3_cnt == 0, "R1 counters after reset", int'(l2_cnt + l3_cnt), 0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [37:0] e;
            e = VEC[v];
            if (e[37]) do_reset();
            send(e[36:35], e[34], e[33:18], l2m, l3m, got);
            check(got, $sformatf("R5 response for vector %0d", v), int'(got), 1);
            check({l2m, l3m} == e[17:16],
                  $sformatf("R6 R7 R8 R9 flags vector %0d", v), int'({l2m, l3m}), int'(e[17:16]));
            check(l2_cnt == CNT_W'(e[15:8]) && l3_cnt == CNT_W'(e[7:0]),
                  $sformatf("R10 counters vector %0d", v),
                  int'(l2_cnt) * 256 + int'(l3_cnt), int'(e[15:8]) * 256 + int'(e[7:0]));
        end

        // R5: handshake timing on a genuine miss
        do_reset();
        @(negedge clk);
        policy    = 2'd0;
        req_valid = 1'b1;
        req_real  = 1'b1;
        req_addr  = 32'h0000_1000;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R5 ready low while busy", int'(req_ready), 0);
        got = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (resp_valid) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check(got && req_ready, "R5 ready back with response", int'(req_ready), 1);
        @(negedge clk);
        check(resp_valid == 1'b0, "R5 single-cycle response", int'(resp_valid), 0);

        // R2: upgrade request to a present line leaves counters alone
        send(2'd0, 1'b0, 16'h1000, l2m, l3m, got);
        check(got && !l2m && !l3m, "R2 upgrade flags", int'({l2m, l3m}), 0);
        check(l2_cnt == 1 && l3_cnt == 1, "R2 counters unchanged", int'(l2_cnt), 1);

        // R4: mid-level hit touches nothing else
        send(2'd0, 1'b1, 16'h1020, l2m, l3m, got);
        check(got && !l2m && !l3m, "R4 hit flags", int'({l2m, l3m}), 0);
        check(l3_cnt == 1, "R4 last-level count unchanged", int'(l3_cnt), 1);

        // R1: reset mid-run clears lines and counters
        do_reset();
        @(negedge clk);
        check(l2_cnt == 0 && l3_cnt == 0, "R1 counters cleared", int'(l2_cnt), 0);
        send(2'd0, 1'b1, 16'h1000, l2m, l3m, got);
        check(got && l2m && l3m, "R1 line invalid after reset", int'({l2m, l3m}), 3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule